// File: doc/BRIEF.md
# Daisy-Chained TDM Serial Transmitter

This block drives one time-division-multiplexed serial line towards a DSP. A frame has `FRAME_SLOTS` slots of `SLOT_W` bit clocks each. The block places its own `LOCAL_CH` sample words in the opening slots. In the slots after those, it re-emits the serial stream it receives from an upstream converter on `tdm_in`. That stream is delayed by the length of the local section. Because of this, several converters wired in a chain can share one data wire, and the device nearest the DSP leads each frame.

A rising edge of the frame clock `fsync`, sampled on a rising bit-clock edge, restarts the bit position. The following falling edge launches the MSB of slot 0. Each sample word is captured once, when a frame starts, and sits left-aligned in its slot with zero padding below it. `tdm_in` is sampled on rising edges, and `tdm_out` changes only on falling edges. An upstream device that launches its own frame on the same falling edges therefore lands exactly `LOCAL_CH` slots later on this block's output. The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `tdm_chain_tx`

## Requirements
- R1: While reset is asserted, and until the first qualifying `fsync` rising edge is sampled, `tdm_out` is 0 whatever `tdm_in` and `local_words` do.
- R2: A rising bit-clock edge that samples `fsync` high, after it was sampled low on the previous rising edge, opens bit position 0. The falling edge after it launches the MSB of slot 0 on `tdm_out`.
- R3: Each later rising edge advances the position by one. After position `FRAME_SLOTS*SLOT_W-1`, the position wraps to 0 and a new frame starts even without an `fsync` edge. An `fsync` edge in mid-frame restarts the frame at position 0.
- R4: Positions 0 to `LOCAL_CH*SLOT_W-1` carry the local channels in ascending order, one slot each: channel c in slot c, with channel c at bits `[c*SAMPLE_W +: SAMPLE_W]` of `local_words`. Each slot is sent MSB first.
- R5: Within a local slot, slot bit b (0 = first sent) carries word bit `SAMPLE_W-1-b` for b < `SAMPLE_W`. The remaining `SLOT_W-SAMPLE_W` bits are 0.
- R6: `local_words` is captured only on the rising edge that opens position 0. Any change at other times leaves the current frame's local slots unchanged.
- R7: In positions `LOCAL_CH*SLOT_W` and above, the output is `tdm_in` delayed. The value sampled on the rising edge that opens position m is sent at position m + `LOCAL_CH*SLOT_W` - 1, continuously across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock shared by the chain |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fsync | input | 1 | Frame clock at the sample rate; its rising edge starts a frame |
| local_words | input | LOCAL_CH*SAMPLE_W | Local sample words, channel 0 in the low bits |
| tdm_in | input | 1 | Serial stream from the upstream device |
| tdm_out | output | 1 | Serial TDM line towards the DSP |

## Verification
The bench builds the block with 8-bit slots, 6-bit samples, two local channels and four slots per frame. That makes a 32-bit frame with a 16-bit forwarding delay and two pad bits per slot. At this size, a walking-one sweep over every sample bit of every channel fits in a few hundred cycles, and every slot position is compared bit by bit against an arithmetic model. The short frame also lets the bench reach free-running wraps, mid-frame restarts and mid-frame word changes, and it checks forwarded data across many frame boundaries.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  typedef enum logic {
    SEG_LOCAL   = 1'b0,
    SEG_FORWARD = 1'b1
  } seg_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int FRAME_BITS = 256,
  parameter int LOCAL_BITS = 128,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic [CW-1:0] pos,
  output logic          frame_start,
  output logic          synced,
  output tdm_chain_pkg::seg_e seg
);
  logic          fs_q, fs_d;
  logic [CW-1:0] pos_q, pos_d;
  logic          synced_q, synced_d;
  logic          sync_edge, wrap;

  always_comb begin
    sync_edge   = fsync & ~fs_q;
    wrap        = synced_q && (pos_q == CW'(FRAME_BITS - 1));
    frame_start = sync_edge | wrap;
    fs_d        = fsync;
    synced_d    = synced_q | sync_edge;
    if (frame_start)   pos_d = '0;
    else if (synced_q) pos_d = pos_q + CW'(1);
    else               pos_d = pos_q;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      fs_q     <= fs_d;
      pos_q    <= pos_d;
      synced_q <= synced_d;
    end
  end

  assign pos    = pos_q;
  assign synced = synced_q;
  assign seg    = (pos_q < CW'(LOCAL_BITS)) ? tdm_chain_pkg::SEG_LOCAL
                                             : tdm_chain_pkg::SEG_FORWARD;

  p_restart_r2: assert property (@(posedge bclk) disable iff (!rst_n)
    (fsync && !fs_q) |=> (pos_q == '0) && synced_q);

  p_advance_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    (synced_q && !(fsync && !fs_q) && pos_q != CW'(FRAME_BITS - 1))
      |=> pos_q == $past(pos_q) + CW'(1));

  p_wrap_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    (synced_q && pos_q == CW'(FRAME_BITS - 1)) |=> pos_q == '0);
endmodule

// File: rtl/tdm_local_shifter.sv
module tdm_local_shifter #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int LOCAL_CH = 4,
  localparam int LOCAL_BITS = SLOT_W * LOCAL_CH,
  localparam int PAD        = SLOT_W - SAMPLE_W
) (
  input  logic                         bclk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [LOCAL_CH*SAMPLE_W-1:0] words,
  output logic                         head_bit
);
  logic [LOCAL_BITS-1:0] packed_w;
  logic [LOCAL_BITS-1:0] sh_q, sh_d;

  for (genvar c = 0; c < LOCAL_CH; c++) begin : g_ch
    if (PAD > 0) begin : g_pad
      assign packed_w[LOCAL_BITS-1-c*SLOT_W -: SLOT_W] =
        {words[c*SAMPLE_W +: SAMPLE_W], {PAD{1'b0}}};
    end else begin : g_full
      assign packed_w[LOCAL_BITS-1-c*SLOT_W -: SLOT_W] = words[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  always_comb begin
    if (load) sh_d = packed_w;
    else      sh_d = {sh_q[LOCAL_BITS-2:0], 1'b0};
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign head_bit = sh_q[LOCAL_BITS-1];
endmodule

// File: rtl/tdm_chain_delay.sv
module tdm_chain_delay #(
  parameter int DEPTH = 128
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] line_q, line_d;

  always_comb line_d = {line_q[DEPTH-2:0], din};

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx #(
  parameter int SLOT_W      = 32,
  parameter int SAMPLE_W    = 24,
  parameter int LOCAL_CH    = 4,
  parameter int FRAME_SLOTS = 8,
  localparam int LOCAL_BITS = SLOT_W * LOCAL_CH,
  localparam int FRAME_BITS = SLOT_W * FRAME_SLOTS,
  localparam int CW         = $clog2(FRAME_BITS),
  localparam int SLOT_LOG   = $clog2(SLOT_W)
) (
  input  logic                         bclk,
  input  logic                         rst_n,
  input  logic                         fsync,
  input  logic [LOCAL_CH*SAMPLE_W-1:0] local_words,
  input  logic                         tdm_in,
  output logic                         tdm_out
);
  import tdm_chain_pkg::*;

  logic          rs0_q, rs1_q, rst_n_i;
  logic [CW-1:0] pos;
  logic          frame_start, synced;
  seg_e          seg;
  logic          sh_bit, dly_bit, bit_d, out_q;
  logic [SLOT_LOG-1:0] slot_bit;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_n_i = rs1_q;

  tdm_frame_timer #(.FRAME_BITS(FRAME_BITS), .LOCAL_BITS(LOCAL_BITS)) i_timer (
    .bclk(bclk), .rst_n(rst_n_i), .fsync(fsync), .pos(pos),
    .frame_start(frame_start), .synced(synced), .seg(seg)
  );

  tdm_local_shifter #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .LOCAL_CH(LOCAL_CH)) i_shift (
    .bclk(bclk), .rst_n(rst_n_i), .load(frame_start), .words(local_words), .head_bit(sh_bit)
  );

  tdm_chain_delay #(.DEPTH(LOCAL_BITS)) i_delay (
    .bclk(bclk), .rst_n(rst_n_i), .din(tdm_in), .dout(dly_bit)
  );

  assign slot_bit = pos[SLOT_LOG-1:0];

  always_comb begin
    if (!synced)               bit_d = 1'b0;
    else if (seg == SEG_LOCAL) bit_d = sh_bit;
    else                       bit_d = dly_bit;
  end

  always_ff @(negedge bclk or negedge rst_n_i) begin
    if (!rst_n_i) out_q <= 1'b0;
    else          out_q <= bit_d;
  end
  assign tdm_out = out_q;

  p_quiet_r1: assert property (@(negedge bclk) disable iff (!rst_n_i)
    !synced |=> tdm_out == 1'b0);

  p_local_r4: assert property (@(negedge bclk) disable iff (!rst_n_i)
    (synced && seg == SEG_LOCAL) |=> tdm_out == $past(sh_bit));

  p_pad_zero_r5: assert property (@(negedge bclk) disable iff (!rst_n_i)
    (synced && seg == SEG_LOCAL && int'(slot_bit) >= SAMPLE_W) |=> tdm_out == 1'b0);

  p_forward_r7: assert property (@(negedge bclk) disable iff (!rst_n_i)
    (synced && seg == SEG_FORWARD) |=> tdm_out == $past(dly_bit));
endmodule

// File: tb/test_tdm_chain_tx.sv
module test_tdm_chain_tx;
  localparam int SW  = 8;
  localparam int SMP = 6;
  localparam int LCH = 2;
  localparam int FS  = 4;
  localparam int LB  = SW * LCH;
  localparam int FB  = SW * FS;
  localparam int WW  = LCH * SMP;

  logic          bclk = 1'b0;
  logic          rst_n;
  logic          fsync;
  logic [WW-1:0] local_words;
  logic          tdm_in;
  logic          tdm_out;

  always #2 bclk = ~bclk;

  tdm_chain_tx #(.SLOT_W(SW), .SAMPLE_W(SMP), .LOCAL_CH(LCH), .FRAME_SLOTS(FS)) i_tdm_chain_tx (
    .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .local_words(local_words),
    .tdm_in(tdm_in), .tdm_out(tdm_out)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference model state
  logic          m_fs_prev = 1'b0;
  logic          m_synced  = 1'b0;
  int            m_pos     = 0;
  logic [WW-1:0] m_lat     = '0;
  logic          hist [0:4095];
  int            n = 0;
  bit            r3_mode = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d pos %0d: got %0b expected %0b", tag, n, m_pos, act, exp);
    end
  endtask

  task automatic step(input logic fs, input logic [WW-1:0] w, input logic d);
    logic  e;
    string tag;
    int    slot, b, src;
    fsync = fs; local_words = w; tdm_in = d;
    @(posedge bclk);
    hist[n] = d;
    if (fs && !m_fs_prev) begin
      m_pos = 0; m_synced = 1'b1; m_lat = w;
    end else if (m_synced) begin
      if (m_pos == FB - 1) begin m_pos = 0; m_lat = w; end
      else m_pos++;
    end
    m_fs_prev = fs;
    if (!m_synced) begin
      e = 1'b0; tag = "R1";
    end else if (m_pos < LB) begin
      slot = m_pos / SW; b = m_pos % SW;
      e = (b < SMP) ? m_lat[slot*SMP + SMP-1-b] : 1'b0;
      if (m_pos == 0)       tag = "R2";
      else if (r3_mode)     tag = "R3";
      else if (b >= SMP)    tag = "R5";
      else if (w !== m_lat) tag = "R6";
      else                  tag = "R4";
    end else begin
      src = n - LB + 1;
      e = (src >= 0) ? hist[src] : 1'b0;
      tag = "R7";
    end
    @(negedge bclk);
    #1;
    check(tag, tdm_out, e);
    n++;
  endtask

  initial begin
    logic [WW-1:0] base;
    rst_n = 1'b0; fsync = 1'b0; local_words = '0; tdm_in = 1'b0;
    repeat (3) @(posedge bclk);
    #1;
    check("R1", tdm_out, 1'b0);              // reset value
    @(negedge bclk); rst_n = 1'b1;
    repeat (4) @(posedge bclk);
    @(negedge bclk); #1;

    // R1: no frame sync yet, inputs toggling
    for (int i = 0; i < 12; i++) step(1'b0, WW'($urandom), 1'($urandom));

    // R2/R4/R5/R6/R7: walking one over every sample bit, then extra patterns
    for (int f = 0; f < WW + 4; f++) begin
      if (f < WW)       base = WW'(1) << f;
      else if (f == WW) base = '1;
      else              base = WW'($urandom);
      for (int p = 0; p < FB; p++)
        step(p < FB/2, (p < 9) ? base : WW'($urandom), 1'($urandom));
    end

    // R3: free-running wraps with no frame-sync edge
    r3_mode = 1'b1;
    for (int f = 0; f < 3; f++) begin
      base = WW'($urandom);
      for (int p = 0; p < FB; p++) step(1'b0, (p == 0) ? base : WW'($urandom), 1'($urandom));
    end

    // R3: restart in mid-frame
    for (int p = 0; p < 20; p++) step(1'b0, WW'($urandom), 1'($urandom));
    for (int f = 0; f < 2; f++) begin
      base = WW'($urandom);
      for (int p = 0; p < FB; p++)
        step(p < FB/2, (p == 0) ? base : WW'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bclk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule